// File: doc/BRIEF.md
# Windowed Video Timing Generator

This block produces the readout timing for an image sensor pixel array, counted in data-clock ticks. A programmable rectangular window selects which pixels are read out. For each pixel in that window the block outputs a row address, a column address and a data-valid flag. It also outputs a horizontal sync and a vertical sync. For each sync the width, start position, polarity and behaviour can be programmed. Row and column subsampling can be set independently. Subsampling walks the array in 2x2 colour-cell steps, so fewer pixels are read per line and fewer lines per frame.

The data clock is the core clock `clk_i` qualified by `en_i`, so an external clock divider only has to pulse `en_i`. All timing settings are plain input ports. They are captured at the first enabled tick after reset and again at each frame boundary, so a frame always runs with one consistent set of settings. Blanking values below the minimum are raised to the minimum. The window column start always has its least significant bit cleared, so every line begins on an even column.

Top module: `win_timing_gen`

## Requirements
- R1: After reset and before the first tick with `en_i` high, `valid_o`, `hsync_o`, `vsync_o`, `row_addr_o` and `col_addr_o` are all 0.
- R2: A line lasts `col_width_i/(col_sub_i+1) + hblank` ticks, with integer division. A frame lasts `row_depth_i/(row_sub_i+1) + vblank` lines. `valid_o` is high on the first effective-width ticks of each of the first effective-depth lines. The subsampling codes are 0 = full, 1 = every 2nd, 2 = every 3rd and 3 = every 4th. The first enabled tick after reset starts line 0 of frame 0.
- R3: An `hblank_i` below 60 behaves as 60. A `vblank_i` below 4 behaves as 4.
- R4: For the i-th valid pixel of a line (i from 0), `col_addr_o` = C + 2k*floor(i/2) + (i mod 2). C is `col_start_i` with bit 0 cleared, and k = `col_sub_i`+1.
- R5: For the j-th valid line of a frame (j from 0), `row_addr_o` = `row_start_i` + 2k*floor(j/2) + (j mod 2), where k = `row_sub_i`+1.
- R6: With `hs_dv_i`=0, the horizontal sync is active on the ticks of every line whose position p in the line satisfies `hs_start_i` <= p < `hs_start_i`+`hs_width_i`.
- R7: With `vs_dv_i`=0, the vertical sync is active on every tick of the lines whose index l in the frame satisfies `vs_start_i` <= l < `vs_start_i`+`vs_width_i`.
- R8: With `hs_dv_i`=1, the horizontal sync is active exactly when `valid_o` is high. With `vs_dv_i`=1, the vertical sync is active on every tick of the valid lines of the frame.
- R9: A polarity bit of 0 makes its sync drive 1 when active. A polarity bit of 1 inverts that sync output.
- R10: On a tick with `en_i` low, no output changes.
- R11: A change of any setting input takes effect at the start of the next frame. Lines already under way in the current frame keep the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Data-clock tick qualifier |
| row_start_i | input | 9 | First row of the window |
| col_start_i | input | 9 | First column of the window (bit 0 ignored) |
| row_depth_i | input | 9 | Window height in rows |
| col_width_i | input | 10 | Window width in columns |
| row_sub_i | input | 2 | Row subsampling code |
| col_sub_i | input | 2 | Column subsampling code |
| hblank_i | input | 14 | Horizontal blanking in ticks |
| vblank_i | input | 13 | Vertical blanking in lines |
| hs_width_i | input | 8 | Horizontal sync width in ticks |
| hs_start_i | input | 10 | Horizontal sync start position in ticks |
| hs_pol_i | input | 1 | Horizontal sync polarity, 1 = active low |
| hs_dv_i | input | 1 | Horizontal sync follows data valid |
| vs_width_i | input | 8 | Vertical sync width in lines |
| vs_start_i | input | 10 | Vertical sync start line |
| vs_pol_i | input | 1 | Vertical sync polarity, 1 = active low |
| vs_dv_i | input | 1 | Vertical sync marks valid lines |
| row_addr_o | output | 10 | Current row address |
| col_addr_o | output | 11 | Current column address |
| valid_o | output | 1 | Pixel data valid |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |

## Verification
The checker watches several properties on every cycle:
- Nothing moves on a tick with the enable low.
- The captured settings change only at a frame boundary or at the first enabled tick.
- The position in the line stays below the line length.
- The line length never falls below the effective width plus the blanking floor.
- While valid, the column address parity follows the pixel index.
- In data-valid mode the horizontal sync follows the valid flag.

The bench scenarios check the rest against a reference model:
- the exact address arithmetic under each subsampling code;
- where the pulses start and end;
- polarity inversion;
- the measured line and frame periods after blanking is clamped;
- the moment a setting changed mid-frame takes hold.

// File: rtl/wtg_pkg.sv
`timescale 1ns/1ps
package wtg_pkg;
  parameter int ROW_W      = 9;
  parameter int COLW_W     = 10;
  parameter int POS_W      = 10;
  parameter int SWD_W      = 8;
  parameter int HBL_W      = 14;
  parameter int VBL_W      = 13;
  parameter int HBLANK_MIN = 60;
  parameter int VBLANK_MIN = 4;

  localparam int HCNT_W  = HBL_W + 1;
  localparam int VCNT_W  = VBL_W + 1;
  localparam int CADDR_W = COLW_W + 1;
  localparam int RADDR_W = ROW_W + 1;

  typedef struct packed {
    logic [ROW_W-1:0]  row_start;
    logic [ROW_W-1:0]  col_start;
    logic [ROW_W-1:0]  row_depth;
    logic [COLW_W-1:0] col_width;
    logic [1:0]        row_sub;
    logic [1:0]        col_sub;
    logic [HBL_W-1:0]  hblank;
    logic [VBL_W-1:0]  vblank;
    logic [SWD_W-1:0]  hs_width;
    logic [SWD_W-1:0]  vs_width;
    logic [POS_W-1:0]  hs_start;
    logic [POS_W-1:0]  vs_start;
    logic              hs_pol;
    logic              vs_pol;
    logic              hs_dv;
    logic              vs_dv;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{
    row_start: ROW_W'(14),   col_start: ROW_W'(14),
    row_depth: ROW_W'(480),  col_width: COLW_W'(640),
    row_sub:   2'd0,         col_sub:   2'd0,
    hblank:    HBL_W'(140),  vblank:    VBL_W'(45),
    hs_width:  SWD_W'(32),   vs_width:  SWD_W'(1),
    hs_start:  POS_W'(0),    vs_start:  POS_W'(0),
    hs_pol:    1'b0,         vs_pol:    1'b0,
    hs_dv:     1'b0,         vs_dv:     1'b0
  };
endpackage

// File: rtl/wtg_subdiv.sv
`timescale 1ns/1ps
// Effective size = size / (code + 1)
module wtg_subdiv #(
  parameter int W = 10
) (
  input  logic [W-1:0] size_i,
  input  logic [1:0]   code_i,
  output logic [W-1:0] eff_o
);
  always_comb begin
    unique case (code_i)
      2'd0:    eff_o = size_i;
      2'd1:    eff_o = size_i >> 1;
      2'd2:    eff_o = size_i / W'(3);
      default: eff_o = size_i >> 2;
    endcase
  end
endmodule

// File: rtl/wtg_cfg_shadow.sv
`timescale 1ns/1ps
module wtg_cfg_shadow
  import wtg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  cfg_t                cfg_i,
  output cfg_t                cfg_o,
  output logic [COLW_W-1:0]   eff_w_o,
  output logic [ROW_W-1:0]    eff_h_o,
  output logic [HCNT_W-1:0]   line_len_o,
  output logic [VCNT_W-1:0]   frame_len_o
);
  cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_i;
    cfg_d.col_start[0] = 1'b0;
    if (cfg_i.hblank < HBL_W'(HBLANK_MIN)) cfg_d.hblank = HBL_W'(HBLANK_MIN);
    if (cfg_i.vblank < VBL_W'(VBLANK_MIN)) cfg_d.vblank = VBL_W'(VBLANK_MIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_RESET;
    else if (load_i) cfg_q <= cfg_d;
  end

  wtg_subdiv #(.W(COLW_W)) u_div_w (
    .size_i(cfg_q.col_width), .code_i(cfg_q.col_sub), .eff_o(eff_w_o)
  );
  wtg_subdiv #(.W(ROW_W)) u_div_h (
    .size_i(cfg_q.row_depth), .code_i(cfg_q.row_sub), .eff_o(eff_h_o)
  );

  assign line_len_o  = HCNT_W'(eff_w_o) + HCNT_W'(cfg_q.hblank);
  assign frame_len_o = VCNT_W'(eff_h_o) + VCNT_W'(cfg_q.vblank);
  assign cfg_o       = cfg_q;
endmodule

// File: rtl/wtg_frame_cnt.sv
`timescale 1ns/1ps
module wtg_frame_cnt
  import wtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [HCNT_W-1:0] line_len_i,
  input  logic [VCNT_W-1:0] frame_len_i,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic [VCNT_W-1:0] vcnt_o,
  output logic              line_end_o,
  output logic              frame_end_o
);
  logic [HCNT_W-1:0] hcnt_q;
  logic [VCNT_W-1:0] vcnt_q;

  assign line_end_o  = (hcnt_q == line_len_i - HCNT_W'(1));
  assign frame_end_o = line_end_o && (vcnt_q == frame_len_i - VCNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (tick_i) begin
      if (line_end_o) begin
        hcnt_q <= '0;
        vcnt_q <= frame_end_o ? '0 : vcnt_q + VCNT_W'(1);
      end else begin
        hcnt_q <= hcnt_q + HCNT_W'(1);
      end
    end
  end

  assign hcnt_o = hcnt_q;
  assign vcnt_o = vcnt_q;
endmodule

// File: rtl/wtg_addr_step.sv
`timescale 1ns/1ps
// Bayer-space stepping: +1 inside a 2x2 cell, +(2k-1) to the next cell
module wtg_addr_step #(
  parameter int AW = 10,
  parameter int BW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          odd_i,
  input  logic [1:0]    sub_i,
  input  logic [BW-1:0] base_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] off_q, jump;

  assign jump = odd_i ? AW'({sub_i, 1'b1}) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (clr_i)  off_q <= '0;
    else if (adv_i)  off_q <= off_q + jump;
  end

  assign addr_o = AW'(base_i) + off_q;
endmodule

// File: rtl/wtg_sync_gen.sv
`timescale 1ns/1ps
module wtg_sync_gen #(
  parameter int CW = 15,
  parameter int PW = 10,
  parameter int WW = 8
) (
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [PW-1:0] start_i,
  input  logic [WW-1:0] width_i,
  input  logic          dv_i,
  input  logic          region_i,
  input  logic          pol_i,
  output logic          sync_o
);
  logic [CW:0] lo, hi;
  logic        pulse, act;

  assign lo     = (CW+1)'(start_i);
  assign hi     = lo + (CW+1)'(width_i);
  assign pulse  = ({1'b0, cnt_i} >= lo) && ({1'b0, cnt_i} < hi);
  assign act    = dv_i ? region_i : pulse;
  assign sync_o = run_i & (act ^ pol_i);
endmodule

// File: rtl/win_timing_gen.sv
`timescale 1ns/1ps
module win_timing_gen
  import wtg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [ROW_W-1:0]    row_start_i,
  input  logic [ROW_W-1:0]    col_start_i,
  input  logic [ROW_W-1:0]    row_depth_i,
  input  logic [COLW_W-1:0]   col_width_i,
  input  logic [1:0]          row_sub_i,
  input  logic [1:0]          col_sub_i,
  input  logic [HBL_W-1:0]    hblank_i,
  input  logic [VBL_W-1:0]    vblank_i,
  input  logic [SWD_W-1:0]    hs_width_i,
  input  logic [POS_W-1:0]    hs_start_i,
  input  logic                hs_pol_i,
  input  logic                hs_dv_i,
  input  logic [SWD_W-1:0]    vs_width_i,
  input  logic [POS_W-1:0]    vs_start_i,
  input  logic                vs_pol_i,
  input  logic                vs_dv_i,
  output logic [RADDR_W-1:0]  row_addr_o,
  output logic [CADDR_W-1:0]  col_addr_o,
  output logic                valid_o,
  output logic                hsync_o,
  output logic                vsync_o
);
  cfg_t               cfg_in, cfg_q;
  logic [COLW_W-1:0]  eff_w;
  logic [ROW_W-1:0]   eff_h;
  logic [HCNT_W-1:0]  line_len, hcnt;
  logic [VCNT_W-1:0]  frame_len, vcnt;
  logic               line_end, frame_end;
  logic               run_q, tick, load, row_act;
  logic [RADDR_W-1:0] row_raw;
  logic [CADDR_W-1:0] col_raw;

  always_comb begin
    cfg_in           = CFG_RESET;
    cfg_in.row_start = row_start_i;
    cfg_in.col_start = col_start_i;
    cfg_in.row_depth = row_depth_i;
    cfg_in.col_width = col_width_i;
    cfg_in.row_sub   = row_sub_i;
    cfg_in.col_sub   = col_sub_i;
    cfg_in.hblank    = hblank_i;
    cfg_in.vblank    = vblank_i;
    cfg_in.hs_width  = hs_width_i;
    cfg_in.vs_width  = vs_width_i;
    cfg_in.hs_start  = hs_start_i;
    cfg_in.vs_start  = vs_start_i;
    cfg_in.hs_pol    = hs_pol_i;
    cfg_in.vs_pol    = vs_pol_i;
    cfg_in.hs_dv     = hs_dv_i;
    cfg_in.vs_dv     = vs_dv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_q | en_i;
  end

  assign tick = en_i & run_q;
  // first tick after reset and every frame wrap capture the settings
  assign load = en_i & (~run_q | frame_end);

  wtg_cfg_shadow u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .cfg_i(cfg_in),
    .cfg_o(cfg_q), .eff_w_o(eff_w), .eff_h_o(eff_h),
    .line_len_o(line_len), .frame_len_o(frame_len)
  );

  wtg_frame_cnt u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .line_len_i(line_len), .frame_len_i(frame_len),
    .hcnt_o(hcnt), .vcnt_o(vcnt),
    .line_end_o(line_end), .frame_end_o(frame_end)
  );

  wtg_addr_step #(.AW(CADDR_W), .BW(ROW_W)) u_col (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(tick & line_end), .adv_i(tick & ~line_end), .odd_i(hcnt[0]),
    .sub_i(cfg_q.col_sub), .base_i(cfg_q.col_start), .addr_o(col_raw)
  );

  wtg_addr_step #(.AW(RADDR_W), .BW(ROW_W)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(tick & frame_end), .adv_i(tick & line_end & ~frame_end),
    .odd_i(vcnt[0]),
    .sub_i(cfg_q.row_sub), .base_i(cfg_q.row_start), .addr_o(row_raw)
  );

  assign row_act = (vcnt < VCNT_W'(eff_h));
  assign valid_o = run_q & row_act & (hcnt < HCNT_W'(eff_w));

  assign row_addr_o = run_q ? row_raw : '0;
  assign col_addr_o = run_q ? col_raw : '0;

  wtg_sync_gen #(.CW(HCNT_W), .PW(POS_W), .WW(SWD_W)) u_hs (
    .run_i(run_q), .cnt_i(hcnt), .start_i(cfg_q.hs_start),
    .width_i(cfg_q.hs_width), .dv_i(cfg_q.hs_dv), .region_i(valid_o),
    .pol_i(cfg_q.hs_pol), .sync_o(hsync_o)
  );

  wtg_sync_gen #(.CW(VCNT_W), .PW(POS_W), .WW(SWD_W)) u_vs (
    .run_i(run_q), .cnt_i(vcnt), .start_i(cfg_q.vs_start),
    .width_i(cfg_q.vs_width), .dv_i(cfg_q.vs_dv), .region_i(row_act),
    .pol_i(cfg_q.vs_pol), .sync_o(vsync_o)
  );
endmodule

// File: rtl/wtg_checker.sv
`timescale 1ns/1ps
module wtg_checker
  import wtg_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               run_i,
  input cfg_t               cfg_i,
  input logic [COLW_W-1:0]  eff_w_i,
  input logic [HCNT_W-1:0]  hcnt_i,
  input logic [HCNT_W-1:0]  line_len_i,
  input logic               frame_end_i,
  input logic [RADDR_W-1:0] row_addr_i,
  input logic [CADDR_W-1:0] col_addr_i,
  input logic               valid_i,
  input logic               hsync_i,
  input logic               vsync_i
);
  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({row_addr_i, col_addr_i, valid_i, hsync_i, vsync_i}));

  // R11
  cfg_frame_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && (frame_end_i || !run_i)) |=> $stable(cfg_i));

  // R2
  line_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (hcnt_i < line_len_i));

  // R3
  hblank_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (line_len_i >= HCNT_W'(eff_w_i) + HCNT_W'(HBLANK_MIN)));

  // R4
  col_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (col_addr_i[0] == hcnt_i[0]));

  // R8
  hs_follow_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_i.hs_dv) |-> (hsync_i == (valid_i ^ cfg_i.hs_pol)));
endmodule

bind win_timing_gen wtg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run_i(run_q),
  .cfg_i(cfg_q), .eff_w_i(eff_w), .hcnt_i(hcnt), .line_len_i(line_len),
  .frame_end_i(frame_end), .row_addr_i(row_addr_o), .col_addr_i(col_addr_o),
  .valid_i(valid_o), .hsync_i(hsync_o), .vsync_i(vsync_o)
);

// File: tb/win_timing_gen_test.sv
`timescale 1ns/1ps
module win_timing_gen_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [8:0]  row_start_i, col_start_i, row_depth_i;
  logic [9:0]  col_width_i;
  logic [1:0]  row_sub_i, col_sub_i;
  logic [13:0] hblank_i;
  logic [12:0] vblank_i;
  logic [7:0]  hs_width_i, vs_width_i;
  logic [9:0]  hs_start_i, vs_start_i;
  logic        hs_pol_i, hs_dv_i, vs_pol_i, vs_dv_i;
  logic [9:0]  row_addr_o;
  logic [10:0] col_addr_o;
  logic        valid_o, hsync_o, vsync_o;

  int n_chk = 0, n_fail = 0;
  int m_run, m_h, m_v;
  int s_rs, s_cs, s_rd, s_cw, s_rsub, s_csub, s_hb, s_vb;
  int s_hsw, s_hss, s_hsp, s_hsd, s_vsw, s_vss, s_vsp, s_vsd;

  always #2.5 clk_i = ~clk_i;

  win_timing_gen uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic int effw(); return s_cw / (s_csub + 1); endfunction
  function automatic int effh(); return s_rd / (s_rsub + 1); endfunction
  function automatic int llen(); return effw() + s_hb; endfunction
  function automatic int flen(); return effh() + s_vb; endfunction

  task automatic load();
    s_rs = row_start_i; s_cs = col_start_i & ~1; s_rd = row_depth_i; s_cw = col_width_i;
    s_rsub = row_sub_i; s_csub = col_sub_i;
    s_hb = (hblank_i < 60) ? 60 : hblank_i;
    s_vb = (vblank_i < 4) ? 4 : vblank_i;
    s_hsw = hs_width_i; s_hss = hs_start_i; s_hsp = hs_pol_i; s_hsd = hs_dv_i;
    s_vsw = vs_width_i; s_vss = vs_start_i; s_vsp = vs_pol_i; s_vsd = vs_dv_i;
  endtask

  task automatic model_adv();
    if (m_run == 0) begin
      m_run = 1; load();
    end else if (m_h == llen() - 1) begin
      m_h = 0;
      if (m_v == flen() - 1) begin m_v = 0; load(); end
      else m_v++;
    end else m_h++;
  endtask

  task automatic compare();
    bit ev, ha, va, eh, evs;
    int ec, er;
    ev = (m_run != 0) && (m_h < effw()) && (m_v < effh());
    chk(valid_o == ev, "R2", valid_o, ev);
    if (ev) begin
      ec = s_cs + (m_h / 2) * 2 * (s_csub + 1) + (m_h % 2);
      er = s_rs + (m_v / 2) * 2 * (s_rsub + 1) + (m_v % 2);
      chk(col_addr_o == 11'(ec), "R4", col_addr_o, ec);
      chk(row_addr_o == 10'(er), "R5", row_addr_o, er);
    end
    ha  = s_hsd ? ev : (m_h >= s_hss && m_h < s_hss + s_hsw);
    va  = s_vsd ? (m_v < effh()) : (m_v >= s_vss && m_v < s_vss + s_vsw);
    eh  = (m_run != 0) && (ha ^ s_hsp[0]);
    evs = (m_run != 0) && (va ^ s_vsp[0]);
    chk(hsync_o == eh, s_hsd ? "R8" : (s_hsp ? "R9" : "R6"), hsync_o, eh);
    chk(vsync_o == evs, s_vsd ? "R8" : (s_vsp ? "R9" : "R7"), vsync_o, evs);
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic tick(input bit e);
    en_i = e;
    @(posedge clk_i);
    if (e) model_adv();
    @(negedge clk_i);
    compare();
  endtask

  task automatic set_cfg(input int rs, cs, rd, cw, rsub, csub, hb, vb,
                         input int hsw, hss, hsp, hsd, vsw, vss, vsp, vsd);
    row_start_i = 9'(rs); col_start_i = 9'(cs); row_depth_i = 9'(rd);
    col_width_i = 10'(cw); row_sub_i = 2'(rsub); col_sub_i = 2'(csub);
    hblank_i = 14'(hb); vblank_i = 13'(vb);
    hs_width_i = 8'(hsw); hs_start_i = 10'(hss); hs_pol_i = hsp[0]; hs_dv_i = hsd[0];
    vs_width_i = 8'(vsw); vs_start_i = 10'(vss); vs_pol_i = vsp[0]; vs_dv_i = vsd[0];
  endtask

  task automatic t_reset();
    m_run = 0; m_h = 0; m_v = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) tick(1'b0);
    // R1: everything low before the first enabled tick
    chk(valid_o == 1'b0, "R1", valid_o, 0);
    chk(hsync_o == 1'b0, "R1", hsync_o, 0);
    chk(vsync_o == 1'b0, "R1", vsync_o, 0);
    chk(row_addr_o == '0, "R1", row_addr_o, 0);
    chk(col_addr_o == '0, "R1", col_addr_o, 0);
  endtask

  task automatic t_basic();  // R2 R4 R5 R6 R7
    repeat (1400) tick(1'b1);
  endtask

  task automatic t_subsample();  // 3x columns, 4x rows
    set_cfg(7, 10, 8, 12, 3, 2, 60, 4, 3, 1, 0, 0, 1, 2, 0, 0);
    repeat (2200) tick(1'b1);
  endtask

  task automatic t_dv_pol();  // R8 R9
    set_cfg(20, 3, 6, 10, 1, 1, 61, 5, 4, 0, 1, 1, 1, 0, 1, 1);
    repeat (1200) tick(1'b1);
    set_cfg(20, 3, 6, 10, 1, 1, 61, 5, 4, 2, 1, 0, 2, 1, 1, 0);
    repeat (1400) tick(1'b1);
  endtask

  task automatic t_clamp();
    int n;
    bit prev;
    set_cfg(2, 6, 4, 6, 0, 0, 10, 1, 2, 0, 0, 0, 1, 0, 0, 0);
    while (!(m_h == 0 && m_v == 0 && s_cw == 6)) tick(1'b1);
    n = 0; prev = valid_o;
    do begin tick(1'b1); n++; if (valid_o && !prev) break; prev = valid_o; end while (1);
    chk(n == 66, "R3", n, 66);  // line = 6 + 60
    while (!(m_h == 0 && m_v == 0)) tick(1'b1);
    n = 0; prev = vsync_o;
    do begin tick(1'b1); n++; if (vsync_o && !prev) break; prev = vsync_o; end while (1);
    chk(n == 66 * 8, "R3", n, 66 * 8);  // frame = (4 + 4) lines
  endtask

  task automatic t_enable();
    set_cfg(1, 2, 6, 10, 0, 0, 60, 4, 5, 3, 0, 0, 2, 1, 0, 0);
    for (int i = 0; i < 900; i++) begin
      bit e;
      logic [23:0] snap;
      e = (i % 3) != 0;
      snap = {row_addr_o, col_addr_o, valid_o, hsync_o, vsync_o};
      tick(e);
      if (!e) chk(snap == {row_addr_o, col_addr_o, valid_o, hsync_o, vsync_o},
                  "R10", int'(snap), int'({row_addr_o, col_addr_o, valid_o, hsync_o, vsync_o}));
    end
  endtask

  task automatic t_midframe();
    int cnt;
    set_cfg(4, 8, 6, 8, 0, 0, 60, 4, 5, 3, 0, 0, 1, 0, 0, 0);
    while (!(m_h == 0 && m_v == 0 && s_cw == 8)) tick(1'b1);
    repeat (100) tick(1'b1);
    col_width_i = 10'd16;
    while (m_h != 0) tick(1'b1);
    cnt = 0;
    repeat (68) begin if (valid_o) cnt++; tick(1'b1); end
    chk(cnt == 8, "R11", cnt, 8);    // old width kept in current frame
    while (!(m_h == 0 && m_v == 0)) tick(1'b1);
    cnt = 0;
    repeat (76) begin if (valid_o) cnt++; tick(1'b1); end
    chk(cnt == 16, "R11", cnt, 16);  // new width from next frame
  endtask

  initial begin
    set_cfg(3, 5, 6, 8, 0, 0, 60, 4, 5, 2, 0, 0, 2, 1, 0, 0);
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_subsample();
    t_dv_pol();
    t_clamp();
    t_enable();
    t_midframe();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule